// File: doc/BRIEF.md
# Boundary-Pausing Memory Transfer Engine

This block is the single-buffer DMA path of a storage host controller. Software loads a start address into the system address register, sets a block size and a block count, and pulses a start strobe. The engine then moves the data as 32-bit beats between the controller's data buffer and system memory over a simple request/ready memory port. Each beat advances the address by four bytes.

Whenever the address after a beat lands on a 512 KiB aligned boundary, the engine stops issuing requests. It raises a DMA interrupt status bit and waits. While it waits, the system address register reads back the next address it would have used. Writing that register, with the same value or a new one, resumes the transfer from the written address with the remaining count unchanged. A transfer-complete status bit is raised once every requested byte has moved. Status bits are write-one-to-clear, are gated by a status enable register, and drive an interrupt line through a separate signal enable mask.

Top module: `blkdma_top`

## Requirements
- R1: After reset the system address, status, status enable and signal enable registers read 0, `mem_req` is low and `irq` is low.
- R2: A write to register select 0 (system address) while the engine is idle only loads the start address, which reads back unchanged, and no memory request is made until `xfer_start` is pulsed.
- R3: After `xfer_start`, the engine issues `blk_size*blk_count/4` beats. The first beat is at the loaded address and each later one is 4 higher. The address holds while `mem_ready` is low. `mem_we` follows `to_mem`, and each beat pops (`to_mem`=1) or pushes (`to_mem`=0) the buffer once, with the data passed straight through.
- R4: When a beat that is not the last leaves the next address with its low 19 bits all zero, the engine stops requesting. It sets status bit 3 (DMA boundary) if status enable bit 3 is set.
- R5: While paused, register select 0 reads the next address to be used, and the engine does not resume by itself.
- R6: A system address write while paused resumes the transfer from the written address with the remaining beat count preserved.
- R7: Status bit 1 (transfer complete) is set after the final beat. When the final beat lands on a boundary, bit 1 is set, bit 3 stays clear and the engine is idle.
- R8: Writing 1 to a bit of register select 1 (status) clears it. Writing 0 leaves it unchanged.
- R9: A status bit latches only while its bit in register select 2 (status enable) is set. Bit 0 is command done (`ev_cmd_done`), bit 1 transfer complete, bit 3 DMA boundary, bit 4 write-buffer ready (`ev_wr_ready`), bit 5 read-buffer ready (`ev_rd_ready`). Pausing itself does not depend on the enable.
- R10: When a status event and a write-one-to-clear of the same bit fall in the same cycle, the bit ends up set.
- R11: `irq` is high exactly when some status bit is set whose bit in register select 3 (signal enable) is also set.
- R12: System address writes while the engine is running are ignored.
- R13: A start with a zero byte length sets transfer complete without any memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 system address, 1 status, 2 status enable, 3 signal enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |
| blk_size | input | 12 | Bytes per block |
| blk_count | input | 16 | Number of blocks |
| xfer_start | input | 1 | One-cycle start strobe |
| to_mem | input | 1 | 1: buffer to memory (memory write), 0: memory to buffer |
| ev_cmd_done | input | 1 | Command done event |
| ev_wr_ready | input | 1 | Write-buffer ready event |
| ev_rd_ready | input | 1 | Read-buffer ready event |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address |
| mem_ready | input | 1 | Memory accepts the beat this cycle |
| mem_wdata | output | 32 | Data to memory |
| mem_rdata | input | 32 | Data from memory |
| buf_rdata | input | 32 | Buffer head data |
| buf_pop | output | 1 | Buffer pop on a memory-write beat |
| buf_wdata | output | 32 | Data into buffer |
| buf_push | output | 1 | Buffer push on a memory-read beat |
| irq | output | 1 | Interrupt line |

## Verification
Two pairs of functions can land in one cycle. The first is the final beat of a transfer reaching a 512 KiB boundary. It is provoked by starting 32 bytes below the boundary, and it is judged by transfer complete being set while the boundary bit stays clear and no request follows. The second is a status event meeting a write-one-to-clear of the same bit. It is provoked by driving the command-done event in the same cycle as a status write of bit 0, and it is judged by the bit reading back as set.

// File: rtl/blkdma_pkg.sv
// Package: shared constants and types for the boundary-pausing DMA engine.
// Assumes register data is at least STAT_W bits wide.
package blkdma_pkg;
    localparam int STAT_W = 16;
    // Register selects
    localparam logic [1:0] SEL_SADDR = 2'd0;
    localparam logic [1:0] SEL_STAT  = 2'd1;
    localparam logic [1:0] SEL_STEN  = 2'd2;
    localparam logic [1:0] SEL_SGEN  = 2'd3;
    // Status bit positions
    localparam int B_CMD  = 0;
    localparam int B_XFER = 1;
    localparam int B_DMA  = 3;
    localparam int B_WRDY = 4;
    localparam int B_RRDY = 5;
    localparam logic [STAT_W-1:0] STAT_IMPL = 16'h003B;

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HOLD} xfer_state_e;
endpackage

// File: rtl/blkdma_xfer.sv
// Transfer sequencer: walks the address in 4-byte beats, counts down the
// remaining beats, and parks at every 2**BND_LOG2 aligned address until a new
// address is loaded. Assumes len_words is stable during the start strobe.
module blkdma_xfer
    import blkdma_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LEN_W    = 28,
    parameter int BND_LOG2 = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  len_words,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              mem_ready,
    output logic              mem_req,
    output logic [ADDR_W-1:0] addr_q,
    output logic              beat,
    output logic              ev_done,
    output logic              ev_bnd
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    xfer_state_e        state_q;
    logic [LEN_W-1:0]   rem_q;
    logic [ADDR_W-1:0]  addr_inc;
    logic               last_beat;
    logic               on_bnd;

    // Beat qualification and next-address boundary decode
    always_comb begin
        beat      = (state_q == ST_RUN) && mem_ready;
        addr_inc  = addr_q + STEP;
        last_beat = (rem_q == LEN_W'(1));
        on_bnd    = (addr_inc[BND_LOG2-1:0] == '0);
        mem_req   = (state_q == ST_RUN);
        ev_done   = (beat && last_beat) ||
                    ((state_q == ST_IDLE) && start && (len_words == '0));
        ev_bnd    = beat && !last_beat && on_bnd;
    end

    // Sequencer state, address and remaining-beat count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            rem_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (load_en) addr_q <= load_addr;
                    if (start) begin
                        rem_q <= len_words;
                        if (len_words != '0) state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (beat) begin
                        addr_q <= addr_inc;
                        rem_q  <= rem_q - LEN_W'(1);
                        if (last_beat)   state_q <= ST_IDLE;
                        else if (on_bnd) state_q <= ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (load_en) begin
                        addr_q  <= load_addr;
                        state_q <= ST_RUN;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R4
    bnd_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_bnd |=> (!mem_req && (addr_q[BND_LOG2-1:0] == '0)));
    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat |=> (addr_q == $past(addr_q) + STEP));
    // R5
    hold_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !load_en) |=> (!mem_req && $stable(addr_q)));
    // R12
    run_ignore_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !beat) |=> $stable(addr_q));
    // R6
    resume_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && load_en) |=> (mem_req && $stable(rem_q)));
endmodule

// File: rtl/blkdma_status.sv
// Interrupt status block: write-one-to-clear status bits gated by a status
// enable register, and an interrupt line masked by a signal enable register.
// A set event wins over a clear in the same cycle.
module blkdma_status
    import blkdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_vec,
    input  logic              wr_stat,
    input  logic              wr_sten,
    input  logic              wr_sgen,
    input  logic [STAT_W-1:0] wdata,
    output logic [STAT_W-1:0] stat_q,
    output logic [STAT_W-1:0] sten_q,
    output logic [STAT_W-1:0] sgen_q,
    output logic              irq
);
    logic [STAT_W-1:0] set_g;
    logic [STAT_W-1:0] clr;

    // Gated set terms and clear mask
    always_comb begin
        set_g = set_vec & sten_q & STAT_IMPL;
        clr   = wr_stat ? wdata : '0;
        irq   = |(stat_q & sgen_q);
    end

    // Status, status enable and signal enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            sten_q <= '0;
            sgen_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr) | set_g;
            if (wr_sten) sten_q <= wdata;
            if (wr_sgen) sgen_q <= wdata;
        end
    end

    // R8
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> ((stat_q & $past(wdata & ~set_g)) == '0));
    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_g != '0) |=> ((stat_q & $past(set_g)) == $past(set_g)));
    // R9
    latch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(sten_q)) == '0));
endmodule

// File: rtl/blkdma_top.sv
// Boundary-pausing DMA engine top: register decode and readback, transfer
// length computation, direction capture and memory/buffer data steering.
// Assumes blk_size is a multiple of 4 and REG_W >= ADDR_W >= STAT_W.
module blkdma_top
    import blkdma_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int REG_W    = 32,
    parameter int DATA_W   = 32,
    parameter int BSZ_W    = 12,
    parameter int BCNT_W   = 16,
    parameter int BND_LOG2 = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [BSZ_W-1:0]  blk_size,
    input  logic [BCNT_W-1:0] blk_count,
    input  logic              xfer_start,
    input  logic              to_mem,
    input  logic              ev_cmd_done,
    input  logic              ev_wr_ready,
    input  logic              ev_rd_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ready,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] buf_rdata,
    output logic              buf_pop,
    output logic [DATA_W-1:0] buf_wdata,
    output logic              buf_push,
    output logic              irq
);
    localparam int LEN_W = BSZ_W + BCNT_W;

    logic [LEN_W-1:0]  len_bytes;
    logic [LEN_W-1:0]  len_words;
    logic              load_en, wr_stat, wr_sten, wr_sgen;
    logic              beat, ev_done, ev_bnd;
    logic              dir_q;
    logic [STAT_W-1:0] set_vec, stat_q, sten_q, sgen_q;

    // Register write decode and transfer length
    always_comb begin
        load_en   = reg_wr && (reg_sel == SEL_SADDR);
        wr_stat   = reg_wr && (reg_sel == SEL_STAT);
        wr_sten   = reg_wr && (reg_sel == SEL_STEN);
        wr_sgen   = reg_wr && (reg_sel == SEL_SGEN);
        len_bytes = LEN_W'(blk_size) * LEN_W'(blk_count);
        len_words = len_bytes >> 2;
    end

    // Direction captured at start
    always_ff @(posedge clk) begin
        if (!rst_n)          dir_q <= 1'b0;
        else if (xfer_start) dir_q <= to_mem;
    end

    blkdma_xfer #(
        .ADDR_W   (ADDR_W),
        .LEN_W    (LEN_W),
        .BND_LOG2 (BND_LOG2)
    ) u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (xfer_start),
        .len_words (len_words),
        .load_en   (load_en),
        .load_addr (reg_wdata[ADDR_W-1:0]),
        .mem_ready (mem_ready),
        .mem_req   (mem_req),
        .addr_q    (mem_addr),
        .beat      (beat),
        .ev_done   (ev_done),
        .ev_bnd    (ev_bnd)
    );

    // Status event vector assembly
    always_comb begin
        set_vec         = '0;
        set_vec[B_CMD]  = ev_cmd_done;
        set_vec[B_XFER] = ev_done;
        set_vec[B_DMA]  = ev_bnd;
        set_vec[B_WRDY] = ev_wr_ready;
        set_vec[B_RRDY] = ev_rd_ready;
    end

    blkdma_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .wr_stat (wr_stat),
        .wr_sten (wr_sten),
        .wr_sgen (wr_sgen),
        .wdata   (reg_wdata[STAT_W-1:0]),
        .stat_q  (stat_q),
        .sten_q  (sten_q),
        .sgen_q  (sgen_q),
        .irq     (irq)
    );

    // Data steering between buffer and memory
    always_comb begin
        mem_we    = dir_q;
        mem_wdata = buf_rdata;
        buf_wdata = mem_rdata;
        buf_pop   = beat && dir_q;
        buf_push  = beat && !dir_q;
    end

    // Register readback
    always_comb begin
        case (reg_sel)
            SEL_SADDR: reg_rdata = REG_W'(mem_addr);
            SEL_STAT:  reg_rdata = REG_W'(stat_q);
            SEL_STEN:  reg_rdata = REG_W'(sten_q);
            default:   reg_rdata = REG_W'(sgen_q);
        endcase
    end

    // R7
    done_no_bnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_done |-> !ev_bnd);
    // R3
    one_buf_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({buf_pop, buf_push}) && (beat == (buf_pop || buf_push)));
endmodule

// File: tb/blkdma_top_bench.sv
// Directed bench for blkdma_top: one task per scenario, each checking itself.
module blkdma_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [11:0] blk_size = '0;
    logic [15:0] blk_count = '0;
    logic        xfer_start = 1'b0;
    logic        to_mem = 1'b0;
    logic        ev_cmd_done = 1'b0, ev_wr_ready = 1'b0, ev_rd_ready = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic        mem_ready = 1'b1;
    logic [31:0] mem_wdata, buf_wdata;
    logic [31:0] mem_rdata = 32'h1234_5678;
    logic [31:0] buf_rdata = 32'hA5A5_0001;
    logic        buf_pop, buf_push, irq;

    int n_chk = 0, n_fail = 0;
    int beats = 0, pops = 0, pushes = 0, seq_err = 0;
    logic [31:0] last_addr = '0;
    logic        last_we = 1'b0;
    logic        have_last = 1'b0;

    always #2 clk = ~clk;

    blkdma_top u_blkdma_top (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .blk_size(blk_size),
        .blk_count(blk_count), .xfer_start(xfer_start), .to_mem(to_mem),
        .ev_cmd_done(ev_cmd_done), .ev_wr_ready(ev_wr_ready),
        .ev_rd_ready(ev_rd_ready), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .buf_rdata(buf_rdata), .buf_pop(buf_pop),
        .buf_wdata(buf_wdata), .buf_push(buf_push), .irq(irq)
    );

    // Beat monitor: counts beats and buffer operations, tracks address steps
    always @(posedge clk) begin
        if (rst_n && mem_req && mem_ready) begin
            beats <= beats + 1;
            if (buf_pop) pops <= pops + 1;
            if (buf_push) pushes <= pushes + 1;
            if (have_last && mem_addr != last_addr + 32'd4 &&
                mem_addr[18:0] != 19'd0)
                seq_err <= seq_err + 1;
            last_addr <= mem_addr;
            last_we   <= mem_we;
            have_last <= 1'b1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] sel, output logic [31:0] d);
        @(negedge clk);
        reg_sel = sel;
        #1 d = reg_rdata;
    endtask

    task automatic start_xfer(input logic [11:0] sz, input logic [15:0] cnt, input logic dir);
        @(negedge clk);
        blk_size = sz; blk_count = cnt; to_mem = dir; xfer_start = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0;
    endtask

    task automatic wait_stat(input logic [31:0] mask, input string req);
        logic [31:0] s;
        int n = 0;
        s = '0;
        while ((s & mask) == 0 && n < 600) begin
            reg_read(2'd1, s);
            n++;
        end
        chk(req, s & mask, mask);
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        for (int i = 0; i < 4; i++) begin
            reg_read(2'(i), d);
            chk("R1 reg reset", d, 32'h0);
        end
        chk("R1 mem_req reset", {31'b0, mem_req}, 32'h0);
        chk("R1 irq reset", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_idle_load;
        logic [31:0] d;
        int b0 = beats;
        reg_write(2'd0, 32'h0000_1000);
        idle_cycles(4);
        reg_read(2'd0, d);
        chk("R2 load readback", d, 32'h0000_1000);
        chk("R2 no request", beats - b0, 0);
    endtask

    task automatic t_basic;
        logic [31:0] d;
        int b0, p0;
        reg_write(2'd2, 32'h0000_003B);
        reg_write(2'd3, 32'h0000_0002);
        b0 = beats; p0 = pops;
        start_xfer(12'd16, 16'd2, 1'b1);
        // stall memory and try to move the address while running
        mem_ready = 1'b0;
        @(negedge clk);
        chk("R3 first addr", mem_addr, 32'h0000_1000);
        chk("R3 data to mem", mem_wdata, 32'hA5A5_0001);
        reg_write(2'd0, 32'hDEAD_0000);
        idle_cycles(2);
        chk("R12 running write ignored", mem_addr, 32'h0000_1000);
        mem_ready = 1'b1;
        wait_stat(32'h2, "R7 complete set");
        chk("R3 beat count", beats - b0, 8);
        chk("R3 pops", pops - p0, 8);
        chk("R3 last addr", last_addr, 32'h0000_101C);
        chk("R3 mem_we", {31'b0, last_we}, 32'h1);
        chk("R3 address sequence", seq_err, 0);
        chk("R11 irq on enabled bit", {31'b0, irq}, 32'h1);
        reg_read(2'd0, d);
        chk("R7 next addr after end", d, 32'h0000_1020);
        reg_write(2'd1, 32'h0000_0002);
        #1 chk("R11 irq low after clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_boundary;
        logic [31:0] d;
        int b0, q0;
        reg_write(2'd0, 32'h0007_FFF0);
        reg_write(2'd3, 32'h0000_0008);
        b0 = beats; q0 = pushes;
        start_xfer(12'd32, 16'd1, 1'b0);
        wait_stat(32'h8, "R4 dma bit set");
        chk("R4 beats before pause", beats - b0, 4);
        chk("R4 last addr before pause", last_addr, 32'h0007_FFFC);
        chk("R11 irq on dma bit", {31'b0, irq}, 32'h1);
        idle_cycles(6);
        chk("R5 stays paused", beats - b0, 4);
        chk("R5 no request", {31'b0, mem_req}, 32'h0);
        reg_read(2'd0, d);
        chk("R5 next address", d, 32'h0008_0000);
        reg_write(2'd1, 32'h0000_0008);
        reg_read(2'd1, d);
        chk("R8 w1c dma bit", d & 32'h8, 32'h0);
        reg_write(2'd0, d & 32'h0 | 32'h0008_0000);
        wait_stat(32'h2, "R6 resumes to complete");
        chk("R6 total beats", beats - b0, 8);
        chk("R6 resume addr", last_addr, 32'h0008_000C);
        chk("R3 pushes", pushes - q0, 8);
        reg_write(2'd1, 32'h0000_003B);
    endtask

    task automatic t_end_on_boundary;
        logic [31:0] d;
        int b0;
        reg_write(2'd0, 32'h0007_FFE0);
        b0 = beats;
        start_xfer(12'd32, 16'd1, 1'b1);
        wait_stat(32'h2, "R7 complete on boundary");
        reg_read(2'd1, d);
        chk("R7 dma bit clear at end", d & 32'h8, 32'h0);
        chk("R7 beats", beats - b0, 8);
        idle_cycles(4);
        chk("R7 idle after end", {31'b0, mem_req}, 32'h0);
        reg_read(2'd0, d);
        chk("R7 addr after end", d, 32'h0008_0000);
        reg_write(2'd1, 32'h0000_003B);
    endtask

    task automatic t_enable_off;
        logic [31:0] d;
        int b0;
        reg_write(2'd2, 32'h0000_0003);
        reg_write(2'd0, 32'h0007_FFF8);
        b0 = beats;
        start_xfer(12'd16, 16'd1, 1'b1);
        @(negedge clk);
        ev_wr_ready = 1'b1;
        @(negedge clk);
        ev_wr_ready = 1'b0;
        idle_cycles(12);
        chk("R9 pause without enable", beats - b0, 2);
        reg_read(2'd1, d);
        chk("R9 gated bits stay clear", d & 32'h18, 32'h0);
        chk("R9 irq low", {31'b0, irq}, 32'h0);
        reg_write(2'd0, 32'h0008_0000);
        wait_stat(32'h2, "R6 resume after gated pause");
        chk("R6 beats after gated pause", beats - b0, 4);
        reg_write(2'd1, 32'h0000_003B);
        reg_write(2'd2, 32'h0000_003B);
    endtask

    task automatic t_collision;
        logic [31:0] d;
        reg_write(2'd3, 32'h0000_0001);
        @(negedge clk);
        ev_cmd_done = 1'b1;
        @(negedge clk);
        ev_cmd_done = 1'b0;
        reg_write(2'd1, 32'h0000_0000);
        reg_read(2'd1, d);
        chk("R8 write zero keeps bit", d & 32'h1, 32'h1);
        chk("R11 irq cmd bit", {31'b0, irq}, 32'h1);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 2'd1; reg_wdata = 32'h1; ev_cmd_done = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; ev_cmd_done = 1'b0;
        reg_read(2'd1, d);
        chk("R10 set wins over clear", d & 32'h1, 32'h1);
        reg_write(2'd1, 32'h0000_0001);
        reg_read(2'd1, d);
        chk("R8 clear alone", d & 32'h1, 32'h0);
        @(negedge clk);
        ev_rd_ready = 1'b1;
        @(negedge clk);
        ev_rd_ready = 1'b0;
        reg_read(2'd1, d);
        chk("R9 rd ready latches", d & 32'h20, 32'h20);
        reg_write(2'd1, 32'h0000_003B);
    endtask

    task automatic t_zero_len;
        int b0 = beats;
        start_xfer(12'd16, 16'd0, 1'b1);
        wait_stat(32'h2, "R13 zero length completes");
        chk("R13 no beats", beats - b0, 0);
        reg_write(2'd1, 32'h0000_003B);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_idle_load();
        t_basic();
        t_boundary();
        t_end_on_boundary();
        t_enable_off();
        t_collision();
        t_zero_len();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule